// File: doc/BRIEF.md
# Radix Page-Table Walker

This block turns an effective address into a real address by walking a radix tree of translation tables in memory. A request supplies the effective address, the root table base, the index width of the root level and the total address-space size in bits. On each level the walker forms an entry address, issues a single 64-bit read on a request/response memory port and decodes the returned doubleword. The doubleword is either a directory entry, which names the next table and its index width, or a leaf, which carries the real page number.

When the walk ends at a leaf, the block reports the real address, the final page size in bits, the leaf entry and the address that entry was read from. If a table is missing or the level geometry is illegal, the walk stops with a fault cause instead. Misaligned table bases do not cause a fault. Their low bits are cleared and the walk goes on. Only one read is in flight at any time. The walker accepts a new request only when idle.

Top module: `radix_walker`

## Requirements
- R1: After reset the walker is idle: `busy_o`, `done_o`, `fault_o` and `mem_req_o` are all low.
- R2: On each level the index is the effective address shifted right by (remaining size minus the current index width), masked to the index-width bits. The read address is the aligned table base plus index times 8.
- R3: Before use, the bits of a table base below 2^(index width + 3) are cleared. This holds for the root and for every next-level base.
- R4: Level 0 is legal only with a remaining size of 52 and an index width of 13. Otherwise the walk faults with `fault_badcfg_o` and issues no read.
- R5: Levels 1 and 2 need an index width of 9. Level 3 accepts 9 or 5. Level 4 and beyond are always illegal. Each illegal case faults with `fault_badcfg_o` before any read on that level.
- R6: A returned entry with bit 63 (valid) clear ends the walk with `fault_nopte_o`, and no further read is issued.
- R7: After each valid entry the current index width is subtracted from the remaining size. At the leaf, the remaining size is reported on `page_size_o`.
- R8: A valid entry with bit 62 set is a leaf. Its real page number is entry bits 55:12. `raddr_o` is that page number with its low page-size bits cleared, ORed with the low page-size bits of the effective address.
- R9: A valid entry with bit 62 clear is a directory. The next index width is entry bits 4:0 and the next base is entry bits 55:8 (with bits 7:0 zero). On a leaf, `leaf_pte_o` holds the leaf entry and `pte_addr_o` holds the address it was read from.
- R10: `mem_req_o` is a one-cycle pulse. No new request is raised until `mem_rvalid_i` has returned the pending read.
- R11: `done_o` or `fault_o` pulses for exactly one cycle. The walker is then idle and accepts the next `start_i`. Only one fault cause is set per faulting walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a walk (sampled when idle) |
| eaddr_i | input | 64 | Effective address to translate |
| root_base_i | input | 64 | Root table base |
| root_nls_i | input | 5 | Root index width in bits |
| tree_size_i | input | 6 | Total address-space size in bits |
| mem_req_o | output | 1 | Read request pulse |
| mem_addr_o | output | 64 | Read address |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 64 | Read data (table entry) |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | Walk finished at a leaf (one cycle) |
| fault_o | output | 1 | Walk finished with a fault (one cycle) |
| fault_nopte_o | output | 1 | Fault cause: invalid entry |
| fault_badcfg_o | output | 1 | Fault cause: illegal level geometry |
| raddr_o | output | 64 | Translated real address |
| page_size_o | output | 6 | Final page size in bits |
| leaf_pte_o | output | 64 | Leaf entry |
| pte_addr_o | output | 64 | Address of the leaf entry |

## Verification
The bench sweeps many effective addresses and ends the walk at each possible leaf depth, using both legal last-level widths and a range of read latencies. It checks every fetch address and every result against arithmetic done in the bench. Skewed root and directory bases catch a walker that skips the realignment: it would fetch from an address off by the skew.

The geometry cases are a wrong root size, a wrong root width, a wrong width at level 1, a wrong width at level 3, and a directory at level 3. A walker that checks geometry after the read instead of before would show an extra fetch. A walker that never checks would run past level 3.

A cleared valid bit, at the root and deep in the tree, must stop the walk at once with the invalid-entry cause. A walker that treats such an entry as a directory would issue a further read.

// File: rtl/radix_walk_pkg.sv
package radix_walk_pkg;
  localparam int ENTRY_W  = 64;
  localparam int VALID_B  = 63;
  localparam int LEAF_B   = 62;
  localparam int NLS_W    = 5;
  localparam int NEXT_LSB = 8;
  localparam int NEXT_MSB = 55;
  localparam int RPN_LSB  = 12;
  localparam int RPN_MSB  = 55;

  localparam logic [ENTRY_W-1:0] NEXT_BASE_MASK =
    ((64'd1 << (NEXT_MSB + 1)) - 64'd1) & ~((64'd1 << NEXT_LSB) - 64'd1);
  localparam logic [ENTRY_W-1:0] RPN_MASK =
    ((64'd1 << (RPN_MSB + 1)) - 64'd1) & ~((64'd1 << RPN_LSB) - 64'd1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_WAIT,
    ST_DONE,
    ST_FAULT
  } walk_state_e;
endpackage

// File: rtl/radix_entry_addr.sv
module radix_entry_addr #(
  parameter int ADDR_W = 64,
  parameter int SIZE_W = 6,
  parameter int NLS_W  = 5
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] eaddr_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [NLS_W-1:0]  nls_i,
  output logic [ADDR_W-1:0] entry_addr_o
);
  localparam int SH_W = SIZE_W + 1;

  logic [SH_W-1:0]   shamt;
  logic [NLS_W:0]    algn;
  logic [ADDR_W-1:0] idx;
  logic [ADDR_W-1:0] base_al;

  always_comb begin
    shamt   = {1'b0, size_i} - SH_W'(nls_i);
    algn    = {1'b0, nls_i} + (NLS_W+1)'(3);
    idx     = (eaddr_i >> shamt) & ~({ADDR_W{1'b1}} << nls_i);
    // misaligned bases are silently realigned
    base_al = base_i & ({ADDR_W{1'b1}} << algn);
    entry_addr_o = base_al + (idx << 3);
  end
endmodule

// File: rtl/radix_geom_check.sv
module radix_geom_check #(
  parameter int SIZE_W     = 6,
  parameter int NLS_W      = 5,
  parameter int LVL_W      = 3,
  parameter int ROOT_SIZE  = 52,
  parameter int ROOT_NLS   = 13,
  parameter int MID_NLS    = 9,
  parameter int TAIL_NLS   = 5,
  parameter int LAST_LEVEL = 3
) (
  input  logic [LVL_W-1:0]  level_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [NLS_W-1:0]  nls_i,
  output logic              ok_o
);
  always_comb begin
    if (level_i == '0)
      ok_o = (size_i == SIZE_W'(ROOT_SIZE)) && (nls_i == NLS_W'(ROOT_NLS));
    else if (level_i < LVL_W'(LAST_LEVEL))
      ok_o = (nls_i == NLS_W'(MID_NLS));
    else if (level_i == LVL_W'(LAST_LEVEL))
      ok_o = (nls_i == NLS_W'(MID_NLS)) || (nls_i == NLS_W'(TAIL_NLS));
    else
      ok_o = 1'b0;
  end
endmodule

// File: rtl/radix_leaf_compose.sv
module radix_leaf_compose
  import radix_walk_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int SIZE_W = 6
) (
  input  logic [ENTRY_W-1:0] entry_i,
  input  logic [ADDR_W-1:0]  eaddr_i,
  input  logic [SIZE_W-1:0]  size_i,
  output logic [ADDR_W-1:0]  raddr_o
);
  logic [ADDR_W-1:0] rpn;
  logic [ADDR_W-1:0] pmask;

  always_comb begin
    rpn     = ADDR_W'(entry_i & RPN_MASK);
    pmask   = ~({ADDR_W{1'b1}} << size_i);
    raddr_o = (rpn & ~pmask) | (eaddr_i & pmask);
  end
endmodule

// File: rtl/radix_walker.sv
module radix_walker
  import radix_walk_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int SIZE_W = 6,
  parameter int LVL_W  = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [ADDR_W-1:0]  eaddr_i,
  input  logic [ADDR_W-1:0]  root_base_i,
  input  logic [NLS_W-1:0]   root_nls_i,
  input  logic [SIZE_W-1:0]  tree_size_i,
  output logic               mem_req_o,
  output logic [ADDR_W-1:0]  mem_addr_o,
  input  logic               mem_rvalid_i,
  input  logic [ENTRY_W-1:0] mem_rdata_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               fault_o,
  output logic               fault_nopte_o,
  output logic               fault_badcfg_o,
  output logic [ADDR_W-1:0]  raddr_o,
  output logic [SIZE_W-1:0]  page_size_o,
  output logic [ENTRY_W-1:0] leaf_pte_o,
  output logic [ADDR_W-1:0]  pte_addr_o
);
  walk_state_e        state_q;
  logic [LVL_W-1:0]   level_q;
  logic [SIZE_W-1:0]  size_q;
  logic [NLS_W-1:0]   nls_q;
  logic [ADDR_W-1:0]  base_q, eaddr_q, fetch_addr_q;
  logic [ADDR_W-1:0]  raddr_q, pte_addr_q;
  logic [SIZE_W-1:0]  psize_q;
  logic [ENTRY_W-1:0] pte_q;
  logic               nopte_q, badcfg_q;

  logic [ADDR_W-1:0]  entry_addr;
  logic               geom_ok;
  logic [SIZE_W-1:0]  size_next;
  logic [ADDR_W-1:0]  leaf_raddr;
  logic [ADDR_W-1:0]  next_base;

  radix_entry_addr #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .NLS_W(NLS_W)) u_addr (
    .base_i(base_q), .eaddr_i(eaddr_q), .size_i(size_q), .nls_i(nls_q),
    .entry_addr_o(entry_addr)
  );

  radix_geom_check #(.SIZE_W(SIZE_W), .NLS_W(NLS_W), .LVL_W(LVL_W)) u_geom (
    .level_i(level_q), .size_i(size_q), .nls_i(nls_q), .ok_o(geom_ok)
  );

  assign size_next = size_q - SIZE_W'(nls_q);

  radix_leaf_compose #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_leaf (
    .entry_i(mem_rdata_i), .eaddr_i(eaddr_q), .size_i(size_next),
    .raddr_o(leaf_raddr)
  );

  assign next_base = ADDR_W'(mem_rdata_i & NEXT_BASE_MASK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      level_q      <= '0;
      size_q       <= '0;
      nls_q        <= '0;
      base_q       <= '0;
      eaddr_q      <= '0;
      fetch_addr_q <= '0;
      raddr_q      <= '0;
      pte_addr_q   <= '0;
      psize_q      <= '0;
      pte_q        <= '0;
      nopte_q      <= 1'b0;
      badcfg_q     <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          eaddr_q  <= eaddr_i;
          base_q   <= root_base_i;
          nls_q    <= root_nls_i;
          size_q   <= tree_size_i;
          level_q  <= '0;
          nopte_q  <= 1'b0;
          badcfg_q <= 1'b0;
          state_q  <= ST_FETCH;
        end
        ST_FETCH: begin
          if (!geom_ok) begin
            badcfg_q <= 1'b1;
            state_q  <= ST_FAULT;
          end else begin
            fetch_addr_q <= entry_addr;
            state_q      <= ST_WAIT;
          end
        end
        ST_WAIT: if (mem_rvalid_i) begin
          if (!mem_rdata_i[VALID_B]) begin
            nopte_q <= 1'b1;
            state_q <= ST_FAULT;
          end else begin
            size_q <= size_next;
            pte_q  <= mem_rdata_i;
            if (mem_rdata_i[LEAF_B]) begin
              raddr_q    <= leaf_raddr;
              psize_q    <= size_next;
              pte_addr_q <= fetch_addr_q;
              state_q    <= ST_DONE;
            end else begin
              nls_q   <= mem_rdata_i[NLS_W-1:0];
              base_q  <= next_base;
              level_q <= level_q + LVL_W'(1);
              state_q <= ST_FETCH;
            end
          end
        end
        ST_DONE, ST_FAULT: state_q <= ST_IDLE;
        default:           state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_req_o      = (state_q == ST_FETCH) && geom_ok;
  assign mem_addr_o     = entry_addr;
  assign busy_o         = (state_q != ST_IDLE);
  assign done_o         = (state_q == ST_DONE);
  assign fault_o        = (state_q == ST_FAULT);
  assign fault_nopte_o  = nopte_q;
  assign fault_badcfg_o = badcfg_q;
  assign raddr_o        = raddr_q;
  assign page_size_o    = psize_q;
  assign leaf_pte_o     = pte_q;
  assign pte_addr_o     = pte_addr_q;

  a_r10_single_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);
  a_r10_no_req_while_waiting: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT) |-> !mem_req_o);
  a_r2_entry_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_addr_o[2:0] == 3'b000));
  a_r5_level_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (level_q <= LVL_W'(3)));
  a_r11_one_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> ($countones({fault_nopte_o, fault_badcfg_o}) == 1));
  a_r11_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || fault_o) |=> !busy_o);
  a_r7_size_shrinks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && mem_rvalid_i && mem_rdata_i[VALID_B]) |=> (size_q < $past(size_q)));
endmodule

// File: tb/sim_radix_walker.sv
`timescale 1ns/1ps
module sim_radix_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [63:0] eaddr = '0, root_base = '0;
  logic [4:0]  root_nls = '0;
  logic [5:0]  tree_size = '0;
  logic        mem_req;
  logic [63:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [63:0] mem_rdata = '0;
  logic        busy, done, fault, f_nopte, f_badcfg;
  logic [63:0] raddr, leaf_pte, pte_addr;
  logic [5:0]  psize;

  always #4 clk = ~clk;

  radix_walker u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .eaddr_i(eaddr),
    .root_base_i(root_base), .root_nls_i(root_nls), .tree_size_i(tree_size),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_rvalid_i(mem_rvalid),
    .mem_rdata_i(mem_rdata), .busy_o(busy), .done_o(done), .fault_o(fault),
    .fault_nopte_o(f_nopte), .fault_badcfg_o(f_badcfg), .raddr_o(raddr),
    .page_size_o(psize), .leaf_pte_o(leaf_pte), .pte_addr_o(pte_addr)
  );

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [63:0] mem [logic [63:0]];
  int lat = 1;
  int fetch_cnt = 0, overlap = 0, pend = 0;
  logic [63:0] fetch_log [8];
  logic [63:0] pend_addr;

  logic [63:0] exp_a [4];
  logic [63:0] exp_raddr, exp_leaf;
  int          exp_size;
  logic [63:0] root_used;
  logic [63:0] leaf_a;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] lowm(input int bits);
    return (bits >= 64) ? '1 : ((64'd1 << bits) - 64'd1);
  endfunction

  // memory responder with configurable latency
  initial begin
    forever begin
      @(negedge clk);
      mem_rvalid = 1'b0;
      if (pend > 0) begin
        if (mem_req) overlap++;
        pend--;
        if (pend == 0) begin
          mem_rvalid = 1'b1;
          mem_rdata  = mem.exists(pend_addr) ? mem[pend_addr] : 64'd0;
        end
      end else if (mem_req) begin
        if (fetch_cnt < 8) fetch_log[fetch_cnt] = mem_addr;
        fetch_cnt++;
        pend_addr = mem_addr;
        pend = lat;
      end
    end
  end

  // build a tree whose leaf sits at leaf_lvl; sk skews table bases
  task automatic build(input logic [63:0] ea, input int leaf_lvl, input int l3nls, input bit sk);
    int n [4];
    logic [63:0] b [4];
    int s;
    logic [63:0] cb, idx, rpn;
    mem.delete();
    n[0] = 13; n[1] = 9; n[2] = 9; n[3] = l3nls;
    b[0] = 64'h0000_0040_0000_0000 | (sk ? 64'h1238 : 64'h0);
    b[1] = 64'h0000_0001_0000_0000 | (sk ? 64'h0700 : 64'h0);
    b[2] = 64'h0000_0002_0000_0000 | (sk ? 64'h0500 : 64'h0);
    b[3] = 64'h0000_0003_0000_0000 | (sk ? 64'h0F00 : 64'h0);
    root_used = b[0];
    s = 52;
    rpn = {ea[31:0], ea[63:32]} ^ 64'h0055_AA00_3C3C_0000;
    for (int l = 0; l <= leaf_lvl; l++) begin
      cb  = b[l] & ~lowm(n[l] + 3);
      idx = (ea >> (s - n[l])) & lowm(n[l]);
      exp_a[l] = cb + (idx << 3);
      s = s - n[l];
      if (l == leaf_lvl) begin
        exp_leaf = 64'hC000_0000_0000_0A5D | (rpn & 64'h00FF_FFFF_FFFF_F000);
        mem[exp_a[l]] = exp_leaf;
        leaf_a = exp_a[l];
      end else begin
        mem[exp_a[l]] = 64'h8000_0000_0000_0000 | (b[l+1] & 64'h00FF_FFFF_FFFF_FF00) | 64'(n[l+1]);
      end
    end
    exp_size  = s;
    exp_raddr = (exp_leaf & 64'h00FF_FFFF_FFFF_F000 & ~lowm(s)) | (ea & lowm(s));
  endtask

  task automatic walk(input logic [63:0] ea, input logic [63:0] rb, input int nls, input int sz);
    int w;
    fetch_cnt = 0;
    @(negedge clk);
    eaddr = ea; root_base = rb; root_nls = 5'(nls); tree_size = 6'(sz);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    w = 0;
    while (!(done || fault) && w < 200) begin
      @(negedge clk);
      w++;
    end
    if (w >= 200) chk("R11 walk timeout", 64'd0, 64'd1);
  endtask

  task automatic end_pulse();
    @(negedge clk);
    chk("R11 end pulse one cycle", {62'd0, done, fault}, 64'd0);
    chk("R11 idle after end", {63'd0, busy}, 64'd0);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog act=%h exp=%h", 64'd0, 64'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy after reset", {63'd0, busy}, 64'd0);
    chk("R1 req after reset", {63'd0, mem_req}, 64'd0);
    chk("R1 done/fault after reset", {62'd0, done, fault}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after release", {62'd0, busy, mem_req}, 64'd0);

    // sweep effective addresses over every leaf depth and latency
    for (int k = 0; k < 8; k++) begin
      for (int v = 0; v < 5; v++) begin
        logic [63:0] ea;
        int ll, l3;
        ea = (64'h9E37_79B9_7F4A_7C15 * 64'(k + 1)) ^ (64'h0123_4567_89AB_CDEF >> k);
        ll = (v > 3) ? 3 : v;
        l3 = (v == 4) ? 5 : 9;
        lat = 1 + ((k + v) % 3);
        build(ea, ll, l3, (k % 2) == 1);
        walk(ea, root_used, 13, 52);
        chk("R8 done raised", {62'd0, done, fault}, 64'd2);
        chk("R2 fetch count", 64'(fetch_cnt), 64'(ll + 1));
        for (int l = 0; l <= ll; l++)
          chk($sformatf("R2 R3 fetch addr level %0d", l), fetch_log[l], exp_a[l]);
        chk("R8 real address", raddr, exp_raddr);
        chk("R7 page size", {58'd0, psize}, 64'(exp_size));
        chk("R9 leaf entry", leaf_pte, exp_leaf);
        chk("R9 leaf entry address", pte_addr, leaf_a);
        chk("R10 overlapping request", 64'(overlap), 64'd0);
        end_pulse();
      end
    end

    lat = 2;
    // R4: wrong root size, wrong root width
    build(64'h0000_1234_5678_9000, 3, 9, 0);
    walk(64'h0000_1234_5678_9000, root_used, 13, 48);
    chk("R4 bad size fault", {61'd0, fault, f_badcfg, f_nopte}, 64'd6);
    chk("R4 bad size no fetch", 64'(fetch_cnt), 64'd0);
    end_pulse();
    walk(64'h0000_1234_5678_9000, root_used, 12, 52);
    chk("R4 bad root nls fault", {61'd0, fault, f_badcfg, f_nopte}, 64'd6);
    chk("R4 bad root nls no fetch", 64'(fetch_cnt), 64'd0);
    end_pulse();

    // R5: level 1 width 8
    build(64'h0007_7654_3210_F000, 3, 9, 0);
    mem[exp_a[0]] = (mem[exp_a[0]] & ~64'h1F) | 64'd8;
    walk(64'h0007_7654_3210_F000, root_used, 13, 52);
    chk("R5 level1 nls fault", {61'd0, fault, f_badcfg, f_nopte}, 64'd6);
    chk("R5 level1 nls fetches", 64'(fetch_cnt), 64'd1);
    end_pulse();

    // R5: level 3 width 7
    build(64'h000A_BCDE_F012_3000, 3, 9, 1);
    mem[exp_a[2]] = (mem[exp_a[2]] & ~64'h1F) | 64'd7;
    walk(64'h000A_BCDE_F012_3000, root_used, 13, 52);
    chk("R5 level3 nls fault", {61'd0, fault, f_badcfg, f_nopte}, 64'd6);
    chk("R5 level3 nls fetches", 64'(fetch_cnt), 64'd3);
    end_pulse();

    // R5: directory at level 3 leads to level 4
    build(64'h0003_3333_4444_5000, 3, 9, 0);
    mem[exp_a[3]] = (mem[exp_a[3]] & ~(64'd1 << 62) & ~64'h1F) | 64'd9;
    walk(64'h0003_3333_4444_5000, root_used, 13, 52);
    chk("R5 level4 fault", {61'd0, fault, f_badcfg, f_nopte}, 64'd6);
    chk("R5 level4 fetches", 64'(fetch_cnt), 64'd4);
    end_pulse();

    // R6: invalid entry at level 2 and at root
    build(64'h000F_0F0F_0F0F_0000, 3, 5, 1);
    mem[exp_a[2]] = mem[exp_a[2]] & ~(64'd1 << 63);
    walk(64'h000F_0F0F_0F0F_0000, root_used, 13, 52);
    chk("R6 nopte level2 fault", {61'd0, fault, f_badcfg, f_nopte}, 64'd5);
    chk("R6 nopte level2 fetches", 64'(fetch_cnt), 64'd3);
    end_pulse();
    mem.delete();
    lat = 3;
    walk(64'h0001_0000_0000_0000, 64'h0000_0040_0000_0000, 13, 52);
    chk("R6 nopte root fault", {61'd0, fault, f_badcfg, f_nopte}, 64'd5);
    chk("R6 nopte root fetches", 64'(fetch_cnt), 64'd1);
    chk("R10 overlapping request", 64'(overlap), 64'd0);
    end_pulse();

    // R11: a good walk right after a fault
    lat = 1;
    build(64'h0000_ABCD_0000_1234, 2, 9, 0);
    walk(64'h0000_ABCD_0000_1234, root_used, 13, 52);
    chk("R11 walk after fault", {62'd0, done, fault}, 64'd2);
    chk("R11 causes cleared", {62'd0, f_badcfg, f_nopte}, 64'd0);
    chk("R8 real address after fault", raddr, exp_raddr);
    end_pulse();

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule